// File: doc/BRIEF.md
# Phase Frequency Detector with Antibacklash Overlap

This block compares two edge streams, a divided reference and a divided feedback, and turns their relative timing into a pair of correction pulses. A reference edge raises the "pump up" output. A feedback edge raises the "pump down" output. Once both are high, they stay high together for a programmable minimum overlap and then drop in the same cycle. The overlap keeps a downstream charge pump out of its dead zone when the loop is close to lock. A short overlap allows a faster comparison rate, and a longer one gives the pump more time to settle.

The whole detector runs on one fast oversampling clock. Each edge arrives as a single-cycle strobe. The overlap lengths are cycle counts in the ratio 2 : 5 : 10, multiplied by a scale parameter. An edge that arrives while the overlap countdown is running is held and applied as soon as the outputs have cleared, so no comparison event is lost. A debug output carries either pulse to an observation pin.

Top module: `pfd_antibacklash`

## Requirements
- R1: While rstN is low, and in the first sample after reset is released, pumpUp, pumpDown and dbgOut are all 0.
- R2: A one-cycle refStrobe sampled while the outputs are not both high drives pumpUp to 1 from the next clock edge. pumpUp stays 1 until the common clear.
- R3: A one-cycle fbStrobe sampled while the outputs are not both high drives pumpDown to 1 from the next clock edge. pumpDown stays 1 until the common clear.
- R4: Once pumpUp and pumpDown are both 1, they stay 1 together for exactly W cycles and then fall in the same cycle. W depends on abSel: 2'b00 gives 2*SCALE cycles, 2'b01 gives 5*SCALE cycles and 2'b10 gives 10*SCALE cycles.
- R5: abSel = 2'b11 gives the same overlap length as 2'b10.
- R6: abSel is sampled in the first cycle of overlap. A change to abSel later in the interval does not alter that interval's length.
- R7: A further strobe on an output that is already high, while the other output is low, has no effect. The output stays high, and the overlap that follows the other edge still lasts W cycles.
- R8: A strobe that arrives while both outputs are high is held. After the common clear, its output is 0 for exactly one cycle and then goes back to 1.
- R9: dbgOut shows pumpUp when dbgSel is 0 and pumpDown when dbgSel is 1, in the same cycle.
- R10: The overlap never lasts longer than 10*SCALE cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| refStrobe | input | 1 | One-cycle pulse for each divided reference edge |
| fbStrobe | input | 1 | One-cycle pulse for each divided feedback edge |
| abSel | input | 2 | Antibacklash overlap select (00 short, 01 middle, 10/11 long) |
| dbgSel | input | 1 | Debug mux select: 0 shows pumpUp, 1 shows pumpDown |
| pumpUp | output | 1 | Pump-up pulse |
| pumpDown | output | 1 | Pump-down pulse |
| dbgOut | output | 1 | Selected pulse for observation |

## Verification
A strobe presented before a clock edge shows on its output one cycle later, because it passes through a single register. With both strobes in the same cycle, the outputs are high for exactly W samples and are low in the sample after the clearing edge. A held strobe brings its output back one cycle after that. The debug output is combinational and matches its source in the same sample. The bench changes inputs on the falling clock edge and samples at the next falling edges. It counts the samples in which both outputs are high and compares that count with W, so every pass or fail rests on an exact cycle count.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  // Strobes passed from the overlap control to the edge datapath
  typedef struct packed {
    logic holdEdges;  // overlap running: new edges are parked, not applied
    logic clrBoth;    // clear both outputs at this edge
  } pfdCtrl_t;

  // Overlap length in cycles for a select code; code 3 aliases code 2
  function automatic int unsigned abWidth(input logic [1:0] sel, input int unsigned scale);
    case (sel)
      2'b00:   abWidth = 2 * scale;
      2'b01:   abWidth = 5 * scale;
      default: abWidth = 10 * scale;
    endcase
  endfunction

endpackage

// File: rtl/pfd_edge_path.sv
module pfd_edge_path
  import pfd_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     refStrobe,
  input  logic     fbStrobe,
  input  pfdCtrl_t ctrl,
  output logic     upQ,
  output logic     dnQ,
  output logic     bothHigh
);

  logic pendRef;
  logic pendFb;

  assign bothHigh = upQ & dnQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upQ     <= 1'b0;
      dnQ     <= 1'b0;
      pendRef <= 1'b0;
      pendFb  <= 1'b0;
    end else if (ctrl.clrBoth) begin
      // common clear; anything arriving now is parked for the next edge
      upQ     <= 1'b0;
      dnQ     <= 1'b0;
      pendRef <= pendRef | refStrobe;
      pendFb  <= pendFb | fbStrobe;
    end else if (ctrl.holdEdges) begin
      pendRef <= pendRef | refStrobe;
      pendFb  <= pendFb | fbStrobe;
    end else begin
      upQ     <= upQ | refStrobe | pendRef;
      dnQ     <= dnQ | fbStrobe | pendFb;
      pendRef <= 1'b0;
      pendFb  <= 1'b0;
    end
  end

endmodule

// File: rtl/pfd_overlap_ctrl.sv
module pfd_overlap_ctrl
  import pfd_pkg::*;
#(
  parameter int unsigned SCALE = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] abSel,
  input  logic       bothHigh,
  output pfdCtrl_t   ctrl
);

  localparam int unsigned LONG_W = 10 * SCALE;
  localparam int unsigned CNT_W  = $clog2(LONG_W + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] widthQ;
  logic [CNT_W-1:0] liveW;
  logic             lastCycle;

  assign liveW     = CNT_W'(abWidth(abSel, SCALE));
  assign lastCycle = bothHigh && (cnt != '0) && (cnt == widthQ - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      widthQ <= CNT_W'(2 * SCALE);
    end else if (!bothHigh) begin
      cnt    <= '0;
    end else if (lastCycle) begin
      cnt    <= '0;
    end else begin
      if (cnt == '0) widthQ <= liveW;  // select captured in first overlap cycle
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    ctrl.clrBoth   = lastCycle;
    ctrl.holdEdges = bothHigh;
  end

endmodule

// File: rtl/pfd_antibacklash.sv
module pfd_antibacklash
  import pfd_pkg::*;
#(
  parameter int unsigned SCALE = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refStrobe,
  input  logic       fbStrobe,
  input  logic [1:0] abSel,
  input  logic       dbgSel,
  output logic       pumpUp,
  output logic       pumpDown,
  output logic       dbgOut
);

  pfdCtrl_t ctrl;
  logic     bothHigh;

  pfd_edge_path u_path (
    .clk       (clk),
    .rstN      (rstN),
    .refStrobe (refStrobe),
    .fbStrobe  (fbStrobe),
    .ctrl      (ctrl),
    .upQ       (pumpUp),
    .dnQ       (pumpDown),
    .bothHigh  (bothHigh)
  );

  pfd_overlap_ctrl #(.SCALE(SCALE)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .abSel    (abSel),
    .bothHigh (bothHigh),
    .ctrl     (ctrl)
  );

  assign dbgOut = dbgSel ? pumpDown : pumpUp;

endmodule

// File: rtl/pfd_antibacklash_chk.sv
module pfd_antibacklash_chk #(
  parameter int unsigned SCALE = 1
) (
  input logic clk,
  input logic rstN,
  input logic refStrobe,
  input logic fbStrobe,
  input logic pumpUp,
  input logic pumpDown
);

  localparam int unsigned LONG_W = 10 * SCALE;
  localparam int unsigned OV_W   = $clog2(LONG_W + 2);

  logic [OV_W-1:0] ovCnt;

  always_ff @(posedge clk) begin
    if (!rstN) ovCnt <= '0;
    else if (pumpUp && pumpDown) ovCnt <= ovCnt + 1'b1;
    else ovCnt <= '0;
  end

  AST_REF_SETS_UP: assert property (@(posedge clk) disable iff (!rstN)
    (refStrobe && !(pumpUp && pumpDown)) |=> pumpUp);  // R2

  AST_FB_SETS_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (fbStrobe && !(pumpUp && pumpDown)) |=> pumpDown);  // R3

  AST_CLEAR_TOGETHER: assert property (@(posedge clk) disable iff (!rstN)
    (pumpUp && pumpDown) |=> (pumpUp == pumpDown));  // R4

  AST_OVERLAP_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    ovCnt <= OV_W'(LONG_W));  // R10

endmodule

bind pfd_antibacklash pfd_antibacklash_chk #(.SCALE(SCALE)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .refStrobe (refStrobe),
  .fbStrobe  (fbStrobe),
  .pumpUp    (pumpUp),
  .pumpDown  (pumpDown)
);

// File: tb/pfd_antibacklash_tb.sv
module pfd_antibacklash_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SCALE      = 1;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refStrobe = 1'b0;
  logic       fbStrobe = 1'b0;
  logic [1:0] abSel = 2'b00;
  logic       dbgSel = 1'b0;
  logic       pumpUp, pumpDown, dbgOut;

  int testsRun = 0;
  int testsFailed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfd_antibacklash #(.SCALE(SCALE)) u_dut (
    .clk(clk), .rstN(rstN), .refStrobe(refStrobe), .fbStrobe(fbStrobe),
    .abSel(abSel), .dbgSel(dbgSel), .pumpUp(pumpUp), .pumpDown(pumpDown), .dbgOut(dbgOut)
  );

  task automatic check(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expW(input logic [1:0] s);
    case (s)
      2'b00:   return 2 * SCALE;
      2'b01:   return 5 * SCALE;
      default: return 10 * SCALE;
    endcase
  endfunction

  // strobes driven for one cycle; returns after the sample that follows it
  task automatic pulse(input logic r, input logic f);
    refStrobe = r; fbStrobe = f;
    @(negedge clk);
    refStrobe = 1'b0; fbStrobe = 1'b0;
  endtask

  // count samples (starting with the current one) where both are high
  task automatic countOverlap(output int n);
    n = 0;
    while (pumpUp && pumpDown && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    idle(3);
    check("R1 up in reset", pumpUp, 0);
    check("R1 down in reset", pumpDown, 0);
    check("R1 dbg in reset", dbgOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 up after reset", pumpUp, 0);
    check("R1 down after reset", pumpDown, 0);
  endtask

  task automatic t_widths();
    int n;
    for (int c = 0; c < 4; c++) begin
      abSel = 2'(c);
      pulse(1'b1, 1'b1);
      countOverlap(n);
      if (c == 3) check("R5 code 11 overlap", n, expW(2'b10));
      else check("R4 overlap length", n, expW(2'(c)));
      check("R4 up cleared", pumpUp, 0);
      check("R4 down cleared", pumpDown, 0);
      idle(2);
    end
  endtask

  task automatic t_refLeads();
    int n;
    abSel = 2'b01;
    dbgSel = 1'b0;
    pulse(1'b1, 1'b0);
    check("R2 up set", pumpUp, 1);
    check("R9 dbg shows up", dbgOut, 1);
    idle(2);
    check("R2 up holds", pumpUp, 1);
    check("R3 down still low", pumpDown, 0);
    pulse(1'b0, 1'b1);
    countOverlap(n);
    check("R4 overlap after ref lead", n, expW(2'b01));
    idle(2);
  endtask

  task automatic t_fbLeadsDbg();
    int n;
    abSel = 2'b00;
    dbgSel = 1'b1;
    pulse(1'b0, 1'b1);
    check("R3 down set", pumpDown, 1);
    check("R3 up still low", pumpUp, 0);
    check("R9 dbg shows down", dbgOut, 1);
    dbgSel = 1'b0;
    #1;
    check("R9 dbg switched to up", dbgOut, 0);
    pulse(1'b1, 1'b0);
    countOverlap(n);
    check("R4 overlap after fb lead", n, expW(2'b00));
    idle(2);
  endtask

  task automatic t_repeatIgnored();
    int n;
    abSel = 2'b01;
    pulse(1'b1, 1'b0);
    idle(1);
    pulse(1'b1, 1'b0);
    check("R7 up unchanged by repeat", pumpUp, 1);
    check("R7 down unaffected", pumpDown, 0);
    pulse(1'b0, 1'b1);
    countOverlap(n);
    check("R7 overlap after repeat", n, expW(2'b01));
    idle(2);
    check("R7 no leftover up", pumpUp, 0);
  endtask

  task automatic t_pending();
    int n;
    abSel = 2'b01;
    pulse(1'b1, 1'b1);
    idle(1);
    pulse(1'b1, 1'b0);  // arrives mid-overlap
    n = 2;
    while (pumpUp && pumpDown && n < 100) begin n++; @(negedge clk); end
    check("R8 overlap unchanged by held edge", n, expW(2'b01));
    check("R8 up low one cycle", pumpUp, 0);
    @(negedge clk);
    check("R8 up restored", pumpUp, 1);
    check("R8 down stays low", pumpDown, 0);
    pulse(1'b0, 1'b1);
    countOverlap(n);
    idle(2);
  endtask

  task automatic t_selChange();
    int n;
    abSel = 2'b10;
    pulse(1'b1, 1'b1);
    n = 0;
    while (pumpUp && pumpDown && n < 100) begin
      n++;
      if (n == 3) abSel = 2'b00;
      @(negedge clk);
    end
    check("R6 select change ignored", n, expW(2'b10));
    idle(2);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_widths();
    t_refLeads();
    t_fbLeadsDbg();
    t_repeatIgnored();
    t_pending();
    t_selChange();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule